// File: doc/BRIEF.md
# Display Register-Write Command Processor

This block walks a queue of packed 64-bit instructions held in memory and turns them into writes on a simple register bus aimed at display registers. Software sets up a small configuration port: a control word, a head pointer and a tail pointer. Writing the tail while the engine is enabled and idle starts a run. The engine fetches one 8-byte slot at a time from the head and keeps going until its fetch pointer equals the tail.

The instruction set covers a no-op, a single register write with per-byte enables, an indexed burst that writes several data words to one register, waits counted in microsecond ticks, scanline starts or vblank pulses, and a one-cycle interrupt pulse. Any other opcode is skipped and latches a sticky error flag. A run can be held until the next vblank, and it can be cancelled at any time through the control word.

Top module: `dcmd_engine`

## Requirements
- R1: Opcode 0x01 in bits 63:56 of a slot performs one register write: reg_addr takes bits 51:32, reg_be takes bits 55:52 and reg_wdata takes the low word, bits 31:0.
- R2: Opcode 0x09 is an indexed burst. The low word is a count N. The next N 32-bit words, taken low half then high half of each following slot, are all written to the offset in bits 51:32 with reg_be 4'hF. When N is odd, the unused high half is skipped. N of 0 writes nothing. The next instruction starts in the slot after the data.
- R3: Opcode 0x00 does nothing. All-zero slots up to the tail are consumed as no-ops, and writes before and after them keep their order.
- R4: Opcodes 0x02, 0x03 and 0x04 wait for as many tick_us, line_start or vblank pulses as the low word gives. The next instruction runs only after the last of those pulses. Pulses of the other two kinds do not count. A count of 0 completes at once.
- R5: Opcode 0x07 raises irq for exactly one cycle.
- R6: Any opcode other than 0x00, 0x01, 0x02, 0x03, 0x04, 0x07 and 0x09 is skipped and sets err. err stays set until a stopping control write.
- R7: Configuration selects are 0 for control, 1 for head and 2 for tail. Control bit 0 enables the engine and bit 1 requests a vblank start. A tail write starts a run only when the engine is enabled and idle and bits 5:0 of the tail are zero. Otherwise it is ignored. busy is high from the cycle after an accepted tail write. A head write must have bits 2:0 zero.
- R8: With control bit 1 set, no fetch or write happens until a vblank pulse arrives after the start.
- R9: A control write with bit 0 clear stops the engine. busy is low in the next cycle, and no further register writes follow. Control writes with any bit above bit 1 set are ignored.
- R10: busy falls after the last instruction before the tail retires. reg_we is never asserted while idle.
- R11: mem_req fetches the 8-byte slot at mem_addr, and mem_rdata is used in the following cycle. Requests are never issued back to back, and they never address outside the head to tail range of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 control, 1 head, 2 tail |
| cfg_wdata | input | AW | Configuration write data |
| mem_req | output | 1 | Slot fetch request |
| mem_addr | output | AW | Byte address of the slot being fetched |
| mem_rdata | input | 64 | Slot contents, one cycle after the request |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 20 | Register offset |
| reg_wdata | output | 32 | Register write data |
| reg_be | output | 4 | Byte enables for the write |
| tick_us | input | 1 | One-cycle microsecond tick |
| line_start | input | 1 | One-cycle scanline start pulse |
| vblank | input | 1 | One-cycle vblank pulse |
| irq | output | 1 | Interrupt pulse |
| busy | output | 1 | Run in progress |
| err | output | 1 | Sticky unsupported-opcode flag |

## Verification
The bench targets bursts of odd, even, single and zero length. An engine that mishandles the pad half or the slot count would write the pad word or lose alignment, and would then decode data as instructions. Waits are fed pulses of the wrong kind and one pulse short of the count, so an engine that releases early or counts any pulse would show a write too soon. The held vblank start, a stop in the middle of a wait, and tail writes that are misaligned or made while disabled are each checked at the busy and write outputs. Unsupported opcodes placed between writes must leave the write stream intact while err latches.

// File: rtl/dcmd_pkg.sv
package dcmd_pkg;

    localparam logic [7:0] OP_NOP  = 8'h00;
    localparam logic [7:0] OP_WR   = 8'h01;
    localparam logic [7:0] OP_WUS  = 8'h02;
    localparam logic [7:0] OP_WLN  = 8'h03;
    localparam logic [7:0] OP_WVB  = 8'h04;
    localparam logic [7:0] OP_IRQ  = 8'h07;
    localparam logic [7:0] OP_IDX  = 8'h09;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_HEAD = 2'd1;
    localparam logic [1:0] SEL_TAIL = 2'd2;

    typedef enum logic [1:0] {EV_US, EV_LINE, EV_VBL} ev_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ARM, S_FETCH, S_DEC, S_BFETCH, S_BLO, S_BHI, S_WAIT
    } st_e;

    typedef struct packed {
        logic [7:0]  op;
        logic [3:0]  be;
        logic [19:0] off;
        logic [31:0] data;
    } instr_t;

    function automatic logic is_wait(input logic [7:0] op);
        return (op == OP_WUS) || (op == OP_WLN) || (op == OP_WVB);
    endfunction

    function automatic ev_e wait_kind(input logic [7:0] op);
        case (op)
            OP_WLN:  return EV_LINE;
            OP_WVB:  return EV_VBL;
            default: return EV_US;
        endcase
    endfunction

endpackage

// File: rtl/dcmd_cfg.sv
module dcmd_cfg
    import dcmd_pkg::*;
#(
    parameter int AW = 16,
    localparam int SW = AW - 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          idle,
    output logic          go,
    output logic          stop,
    output logic          vbl_start,
    output logic [SW-1:0] head_slot,
    output logic [SW-1:0] tail_slot
);
    logic en_q, vbl_q;
    logic ctrl_wr;

    assign ctrl_wr   = cfg_we && (cfg_sel == SEL_CTRL) && (cfg_wdata[AW-1:2] == '0);
    assign stop      = ctrl_wr && !cfg_wdata[0];
    assign go        = cfg_we && (cfg_sel == SEL_TAIL) && en_q && idle
                       && (cfg_wdata[5:0] == 6'd0);
    assign vbl_start = vbl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            vbl_q     <= 1'b0;
            head_slot <= '0;
            tail_slot <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q  <= cfg_wdata[0];
                vbl_q <= cfg_wdata[1];
            end
            if (cfg_we && (cfg_sel == SEL_HEAD) && (cfg_wdata[2:0] == 3'd0))
                head_slot <= cfg_wdata[AW-1:3];
            if (go)
                tail_slot <= cfg_wdata[AW-1:3];
        end
    end

    // R7: an accepted start always leaves a 64-byte aligned tail behind
    assert_tail_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        go |=> (tail_slot[2:0] == 3'd0));

endmodule

// File: rtl/dcmd_wait.sv
module dcmd_wait
    import dcmd_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  ev_e           kind,
    input  logic [CW-1:0] val,
    input  logic          abort,
    input  logic          tick_us,
    input  logic          line_start,
    input  logic          vblank,
    output logic          active
);
    logic [CW-1:0] cnt;
    ev_e           kind_q;
    logic          ev;

    always_comb begin
        case (kind_q)
            EV_LINE: ev = line_start;
            EV_VBL:  ev = vblank;
            default: ev = tick_us;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            kind_q <= EV_US;
        end else if (abort) begin
            active <= 1'b0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= val;
            kind_q <= kind;
        end else if (active && ev) begin
            cnt <= cnt - 1'b1;
            if (cnt == {{(CW-1){1'b0}}, 1'b1})
                active <= 1'b0;
        end
    end

    // R4: a wait only ends on a pulse of its own kind (or an abort)
    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (active && !ev && !abort) |=> active);

endmodule

// File: rtl/dcmd_seq.sv
module dcmd_seq
    import dcmd_pkg::*;
#(
    parameter int AW = 16,
    localparam int SW = AW - 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          stop,
    input  logic          vbl_start,
    input  logic [SW-1:0] head_slot,
    input  logic [SW-1:0] tail_slot,
    input  logic          vblank,
    input  logic          wait_active,
    output logic          wait_load,
    output ev_e           wait_kind_o,
    output logic [31:0]   wait_val,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [63:0]   mem_rdata,
    output logic          reg_we,
    output logic [19:0]   reg_addr,
    output logic [31:0]   reg_wdata,
    output logic [3:0]    reg_be,
    output logic          irq,
    output logic          busy,
    output logic          err
);
    st_e           state;
    logic [SW-1:0] ptr;
    logic [31:0]   bcnt;
    logic [31:0]   hi_q;
    instr_t        ins;
    logic          known;

    assign ins         = instr_t'(mem_rdata);
    assign busy        = (state != S_IDLE);
    assign mem_req     = ((state == S_FETCH) && (ptr != tail_slot)) || (state == S_BFETCH);
    assign mem_addr    = {ptr, 3'b000};
    assign wait_load   = (state == S_DEC) && !stop && is_wait(ins.op) && (ins.data != 32'd0);
    assign wait_kind_o = wait_kind(ins.op);
    assign wait_val    = ins.data;
    assign known       = (ins.op == OP_NOP) || (ins.op == OP_WR) || is_wait(ins.op)
                         || (ins.op == OP_IRQ) || (ins.op == OP_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ptr       <= '0;
            bcnt      <= '0;
            hi_q      <= '0;
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_be    <= '0;
            irq       <= 1'b0;
            err       <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            irq    <= 1'b0;
            if (stop) begin
                state <= S_IDLE;
                err   <= 1'b0;
            end else begin
                case (state)
                    S_IDLE: if (go) begin
                        ptr   <= head_slot;
                        state <= vbl_start ? S_ARM : S_FETCH;
                    end
                    S_ARM: if (vblank) state <= S_FETCH;
                    S_FETCH: state <= (ptr == tail_slot) ? S_IDLE : S_DEC;
                    S_DEC: begin
                        ptr   <= ptr + 1'b1;
                        state <= S_FETCH;
                        if (!known) err <= 1'b1;
                        case (ins.op)
                            OP_WR: begin
                                reg_we    <= 1'b1;
                                reg_addr  <= ins.off;
                                reg_wdata <= ins.data;
                                reg_be    <= ins.be;
                            end
                            OP_IRQ: irq <= 1'b1;
                            OP_IDX: begin
                                reg_addr <= ins.off;
                                reg_be   <= 4'hF;
                                bcnt     <= ins.data;
                                if (ins.data != 32'd0) state <= S_BFETCH;
                            end
                            default: if (wait_load) state <= S_WAIT;
                        endcase
                    end
                    S_BFETCH: state <= S_BLO;
                    S_BLO: begin
                        ptr       <= ptr + 1'b1;
                        reg_we    <= 1'b1;
                        reg_wdata <= mem_rdata[31:0];
                        hi_q      <= mem_rdata[63:32];
                        bcnt      <= bcnt - 1'b1;
                        state     <= (bcnt == 32'd1) ? S_FETCH : S_BHI;
                    end
                    S_BHI: begin
                        reg_we    <= 1'b1;
                        reg_wdata <= hi_q;
                        bcnt      <= bcnt - 1'b1;
                        state     <= (bcnt == 32'd1) ? S_FETCH : S_BFETCH;
                    end
                    S_WAIT: if (!wait_active) state <= S_FETCH;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R10: writes only come out of a running engine
    assert_we_busy_R10: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> ($past(state) != S_IDLE));
    // R11: one slot request outstanding at a time
    assert_single_req_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    // R5: interrupt is a single-cycle pulse
    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    // R9: a stop leaves the engine idle with no write
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!busy && !reg_we));
    // R6: error flag is sticky until a stop
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (err && !stop) |=> err);

endmodule

// File: rtl/dcmd_engine.sv
module dcmd_engine
    import dcmd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [63:0]   mem_rdata,
    output logic          reg_we,
    output logic [19:0]   reg_addr,
    output logic [31:0]   reg_wdata,
    output logic [3:0]    reg_be,
    input  logic          tick_us,
    input  logic          line_start,
    input  logic          vblank,
    output logic          irq,
    output logic          busy,
    output logic          err
);
    localparam int SW = AW - 3;

    logic          go, stop, vbl_start;
    logic [SW-1:0] head_slot, tail_slot;
    logic          wait_load, wait_active;
    ev_e           wait_kind_s;
    logic [31:0]   wait_val;

    dcmd_cfg #(.AW(AW)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .idle(!busy), .go(go), .stop(stop),
        .vbl_start(vbl_start), .head_slot(head_slot), .tail_slot(tail_slot)
    );

    dcmd_wait #(.CW(32)) u_wait (
        .clk(clk), .rst(rst), .load(wait_load), .kind(wait_kind_s),
        .val(wait_val), .abort(stop), .tick_us(tick_us),
        .line_start(line_start), .vblank(vblank), .active(wait_active)
    );

    dcmd_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .go(go), .stop(stop), .vbl_start(vbl_start),
        .head_slot(head_slot), .tail_slot(tail_slot), .vblank(vblank),
        .wait_active(wait_active), .wait_load(wait_load),
        .wait_kind_o(wait_kind_s), .wait_val(wait_val),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_be(reg_be), .irq(irq), .busy(busy), .err(err)
    );

endmodule

// File: tb/sim_dcmd_engine.sv
module sim_dcmd_engine;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_rdata = '0;
    logic          reg_we;
    logic [19:0]   reg_addr;
    logic [31:0]   reg_wdata;
    logic [3:0]    reg_be;
    logic          tick_us = 1'b0, line_start = 1'b0, vblank = 1'b0;
    logic          irq, busy, err;

    always #2.5 clk = ~clk;

    dcmd_engine #(.AW(AW)) u0 (.*);

    logic [63:0] mem [0:255];
    logic [55:0] exp_q [$];
    int checks = 0, errors = 0;
    int wr_seen = 0, irq_seen = 0, irq_exp = 0, cycles = 0;
    logic err_exp = 1'b0;
    int run_head = 0, run_tail = 0;

    always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[10:3]];

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // reference comparison on every clock: write stream, irq pulses, fetch range
    always @(negedge clk) begin
        if (!rst) begin
            cycles++;
            if (reg_we) begin
                wr_seen++;
                if (exp_q.size() == 0)
                    chk(0, "R10 unexpected write", {reg_be, reg_addr, reg_wdata}, 0);
                else begin
                    logic [55:0] e;
                    e = exp_q.pop_front();
                    chk({reg_be, reg_addr, reg_wdata} == e, "R1/R2 write", {reg_be, reg_addr, reg_wdata}, e);
                end
            end
            if (irq) irq_seen++;
            if (mem_req)
                chk(int'(mem_addr) >= run_head && int'(mem_addr) < run_tail, "R11 fetch range",
                    mem_addr, run_head);
        end
    end

    function automatic logic [63:0] mk(input logic [7:0] op, input logic [3:0] be,
                                       input logic [19:0] off, input logic [31:0] d);
        return {op, be, off, d};
    endfunction

    task automatic model(input int hs, input int ts);
        int s;
        s = hs;
        irq_exp = 0;
        err_exp = 1'b0;
        while (s < ts) begin
            logic [63:0] w;
            w = mem[s];
            case (w[63:56])
                8'h00, 8'h02, 8'h03, 8'h04: s++;
                8'h01: begin exp_q.push_back({w[55:52], w[51:32], w[31:0]}); s++; end
                8'h07: begin irq_exp++; s++; end
                8'h09: begin
                    int n;
                    n = int'(w[31:0]);
                    for (int k = 0; k < n; k++) begin
                        logic [63:0] d;
                        d = mem[s + 1 + k / 2];
                        exp_q.push_back({4'hF, w[51:32], (k % 2 == 0) ? d[31:0] : d[63:32]});
                    end
                    s = s + 1 + (n + 1) / 2;
                end
                default: begin err_exp = 1'b1; s++; end
            endcase
        end
    endtask

    task automatic cfg(input logic [1:0] s, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = AW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tick_us = 1'b1;
            1: line_start = 1'b1;
            default: vblank = 1'b1;
        endcase
        @(negedge clk);
        tick_us = 1'b0; line_start = 1'b0; vblank = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = '0;
    endtask

    task automatic start(input int hs, input int ts, input int ctrl, input bit use_model);
        exp_q.delete();
        if (use_model) model(hs, ts);
        wr_seen = 0; irq_seen = 0;
        run_head = hs * 8; run_tail = ts * 8;
        cfg(2'd0, 0);
        cfg(2'd0, ctrl);
        cfg(2'd1, hs * 8);
        cfg(2'd2, ts * 8);
        chk(busy == 1'b1, "R7 busy after tail write", busy, 1);
    endtask

    task automatic finish_run(input string tag);
        int t;
        t = 0;
        while (busy && t < 3000) begin @(negedge clk); t++; end
        chk(!busy, {tag, " R10 busy falls"}, busy, 0);
        chk(exp_q.size() == 0, {tag, " all expected writes seen"}, exp_q.size(), 0);
        chk(irq_seen == irq_exp, {tag, " R5 irq count"}, irq_seen, irq_exp);
        chk(err == err_exp, {tag, " R6 err flag"}, err, err_exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !reg_we && !irq && !err && !mem_req, "reset state", {busy, reg_we, irq, err}, 0);

        // R1 and R3: single writes separated by no-ops, zero fill to tail
        clear_mem();
        mem[0] = mk(8'h01, 4'hF, 20'h00100, 32'h11111111);
        mem[1] = mk(8'h01, 4'h3, 20'h00104, 32'h0000A5A5);
        mem[2] = mk(8'h00, 4'h0, 20'h00000, 32'h12345678);
        mem[3] = mk(8'h01, 4'h8, 20'hFFFFF, 32'hDEADBEEF);
        start(0, 8, 1, 1);
        finish_run("R1 R3 single writes");
        chk(wr_seen == 3, "R3 no-ops write nothing", wr_seen, 3);

        // R2: bursts of odd, even, zero and one word
        clear_mem();
        mem[16] = mk(8'h09, 4'h0, 20'h00200, 32'd3);
        mem[17] = {32'hD1D1D1D1, 32'hD0D0D0D0};
        mem[18] = {32'h0BAD0BAD, 32'hD2D2D2D2};
        mem[19] = mk(8'h09, 4'h0, 20'h00204, 32'd4);
        mem[20] = {32'hE1E1E1E1, 32'hE0E0E0E0};
        mem[21] = {32'hE3E3E3E3, 32'hE2E2E2E2};
        mem[22] = mk(8'h09, 4'h0, 20'h00208, 32'd0);
        mem[23] = mk(8'h09, 4'h0, 20'h0020C, 32'd1);
        mem[24] = {32'h0, 32'hF0F0F0F0};
        mem[25] = mk(8'h01, 4'hF, 20'h00300, 32'hCAFE0001);
        start(16, 32, 1, 1);
        finish_run("R2 bursts");
        chk(wr_seen == 9, "R2 burst word count", wr_seen, 9);

        // R5 and R6: interrupts and unsupported opcodes
        clear_mem();
        mem[32] = mk(8'h07, 4'h0, 20'h0, 32'h0);
        mem[33] = mk(8'h05, 4'hF, 20'h00400, 32'h77777777);
        mem[34] = mk(8'h01, 4'hF, 20'h00404, 32'h00000042);
        mem[35] = mk(8'h0A, 4'hF, 20'h00408, 32'h88888888);
        mem[36] = mk(8'h07, 4'h0, 20'h0, 32'h0);
        mem[37] = mk(8'h33, 4'hF, 20'h0040C, 32'h99999999);
        mem[38] = mk(8'h01, 4'h1, 20'h00410, 32'h00000043);
        start(32, 40, 1, 1);
        finish_run("R5 R6 irq and bad opcodes");
        chk(err == 1'b1, "R6 err still set while idle", err, 1);
        cfg(2'd0, 0);
        chk(err == 1'b0, "R6 err cleared by stop write", err, 0);

        // R8: start held until vblank
        clear_mem();
        mem[40] = mk(8'h01, 4'hF, 20'h00500, 32'h0000B00B);
        start(40, 48, 3, 1);
        repeat (15) @(negedge clk);
        chk(wr_seen == 0 && busy, "R8 held before vblank", wr_seen, 0);
        pulse(2);
        finish_run("R8 vblank start");
        chk(wr_seen == 1, "R8 write after vblank", wr_seen, 1);

        // R4: waits of each kind, wrong kinds ignored, zero count
        clear_mem();
        mem[48] = mk(8'h02, 4'h0, 20'h0, 32'd3);
        mem[49] = mk(8'h01, 4'hF, 20'h00600, 32'h000000A1);
        mem[50] = mk(8'h03, 4'h0, 20'h0, 32'd2);
        mem[51] = mk(8'h01, 4'hF, 20'h00604, 32'h000000B2);
        mem[52] = mk(8'h04, 4'h0, 20'h0, 32'd1);
        mem[53] = mk(8'h01, 4'hF, 20'h00608, 32'h000000C3);
        mem[54] = mk(8'h02, 4'h0, 20'h0, 32'd0);
        mem[55] = mk(8'h01, 4'hF, 20'h0060C, 32'h000000D4);
        start(48, 56, 1, 1);
        repeat (10) @(negedge clk);
        chk(wr_seen == 0, "R4 tick wait holds", wr_seen, 0);
        pulse(0); pulse(0); pulse(1); pulse(2);
        chk(wr_seen == 0, "R4 one tick short and wrong kinds", wr_seen, 0);
        pulse(0);
        repeat (10) @(negedge clk);
        chk(wr_seen == 1, "R4 tick wait released", wr_seen, 1);
        pulse(1); pulse(0);
        chk(wr_seen == 1, "R4 line wait holds", wr_seen, 1);
        pulse(1);
        repeat (10) @(negedge clk);
        chk(wr_seen == 2, "R4 line wait released", wr_seen, 2);
        pulse(0);
        chk(wr_seen == 2, "R4 vblank wait holds", wr_seen, 2);
        pulse(2);
        repeat (10) @(negedge clk);
        chk(wr_seen == 4, "R4 vblank wait and zero wait", wr_seen, 4);
        finish_run("R4 waits");

        // R9: stop in the middle of a wait
        clear_mem();
        mem[56] = mk(8'h02, 4'h0, 20'h0, 32'd100);
        mem[57] = mk(8'h01, 4'hF, 20'h00700, 32'h0000DEAD);
        start(56, 64, 1, 0);
        repeat (5) @(negedge clk);
        cfg(2'd0, 0);
        chk(!busy, "R9 busy low after stop", busy, 0);
        for (int i = 0; i < 5; i++) pulse(0);
        chk(wr_seen == 0 && !busy, "R9 no write after stop", wr_seen, 0);

        // R7: misaligned tail and disabled engine ignore the tail write
        clear_mem();
        mem[0] = mk(8'h01, 4'hF, 20'h00800, 32'h1);
        exp_q.delete(); wr_seen = 0;
        cfg(2'd0, 1);
        cfg(2'd1, 0);
        cfg(2'd2, 32);
        repeat (10) @(negedge clk);
        chk(!busy && wr_seen == 0, "R7 misaligned tail ignored", busy, 0);
        cfg(2'd0, 0);
        cfg(2'd2, 64);
        repeat (10) @(negedge clk);
        chk(!busy && wr_seen == 0, "R7 disabled tail ignored", busy, 0);
        cfg(2'd0, 32'h5);
        cfg(2'd2, 64);
        repeat (10) @(negedge clk);
        chk(!busy && wr_seen == 0, "R9 control with reserved bit ignored", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule